// File: doc/BRIEF.md
# Chopped-Burst Column Command Spacing Checker

This block sits beside the command scheduler of a DDR3 memory controller. It watches column commands (read, write) and precharge commands as they are issued. Each command is tagged as either a full eight-beat burst or a chopped four-beat burst. For whichever command type is presented next, it computes the minimum number of clocks that must pass since the previous command. The scheduler can use the ready output to hold a command back. A command issued too early is still taken as the new reference point, and the violation output is raised for one clock.

The DRAM always prefetches eight beats, so a chopped burst moves only four beats and masks the rest. It is not a true four-beat burst. The checker therefore grants the two-clock saving of a chop only on direction turnarounds and on write recovery before precharge. Two reads in a row, or two writes in a row, keep full eight-beat spacing. The configured latencies (read latency, write latency, additive latency) and the write-to-read and write-recovery times arrive as inputs, so the same instance works across speed grades. Write latency follows the clock period: 5 for 2.5 to 3.3 ns, 6 for 1.875 to 2.5 ns, 7 for 1.5 to 1.875 ns, and 8 for 1.25 to 1.5 ns.

Top module: `bc_spacing_chk`

## Requirements
- R1: After reset, and until the first command is accepted, `cmd_rdy` is 1 for every command code and `spacing_viol` is 0. A synchronous reset also discards any earlier command.
- R2: Read after read, and write after write, need 4 clocks between the two commands, whether or not either one is chopped.
- R3: Write after read needs `cfg_cl + 6 - cfg_cwl` clocks if the read was a full burst, and `cfg_cl + 4 - cfg_cwl` if it was chopped. The result is never less than 1.
- R4: Read after write needs `cfg_cwl + 4 + cfg_twtr` clocks if the write was a full burst, and 2 clocks fewer if it was chopped.
- R5: Precharge after write needs `cfg_al + cfg_cwl + 4 + cfg_twr` clocks if the write was a full burst, and 2 clocks fewer if it was chopped.
- R6: A precharge after a read, and any command after a precharge, have no spacing limit. They may follow 1 clock after the previous command.
- R7: A command accepted while `cmd_rdy` is 0 sets `spacing_viol` to 1 in the following clock only. That command still becomes the previous command for all later spacing.
- R8: Command code 2'b00 (no operation) is ignored even when `cmd_valid` is 1. It causes no violation and does not change the timing of the previous command. The other codes are 2'b01 read, 2'b10 write and 2'b11 precharge.
- R9: The count of clocks since the last command saturates and does not wrap, so a long idle period leaves every command ready.
- R10: `cmd_rdy` follows the code on `cmd_kind` in the same clock. It is 1 exactly when the clocks since the previous command are at least the gap needed for that code. A command issued N clocks after the previous one counts as N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A command is issued this clock |
| cmd_kind | input | 2 | Command code: 00 no-op, 01 read, 10 write, 11 precharge |
| cmd_chop | input | 1 | 1 = chopped four-beat burst, 0 = full eight-beat burst |
| cfg_cl | input | LAT_W | Read latency in clocks |
| cfg_cwl | input | LAT_W | Write latency in clocks |
| cfg_al | input | LAT_W | Additive latency in clocks |
| cfg_twtr | input | LAT_W | Write-to-read internal delay in clocks |
| cfg_twr | input | LAT_W | Write recovery time in clocks |
| cmd_rdy | output | 1 | The code on `cmd_kind` may be issued now |
| spacing_viol | output | 1 | One-clock pulse after an early command |

## Verification
The bench builds the checker with LAT_W set to 4. This makes the internal gap counter 6 bits wide, so it saturates at 63. A single idle stretch of about seventy clocks then shows whether the counter saturates or wraps back to a small value. With read latency 6, write latency 5, additive latency 1, write-to-read 4 and write recovery 6, every turnaround gives a distinct gap (4, 5, 7, 11, 13, 14, 16 and 1). A gap wrongly credited with the chop saving, or denied it, therefore lands on a different clock. A second setting with write latency above read latency reaches the clamp to one clock on write-after-read.

// File: rtl/bc_spacing_pkg.sv
package bc_spacing_pkg;

    typedef enum logic [1:0] {
        CMD_NOP = 2'b00,
        CMD_RD  = 2'b01,
        CMD_WR  = 2'b10,
        CMD_PRE = 2'b11
    } col_cmd_e;

    typedef struct packed {
        col_cmd_e kind;
        logic     chop;
    } cmd_rec_t;

    // Number of non-idle command codes, indexed as code - 1
    localparam int NUM_KIND  = 3;
    // Clocks occupied on the data bus by a full and by a chopped burst
    localparam int FULL_CLK  = 4;
    localparam int CHOP_CLK  = 2;
    // Bus turnaround allowance on read-to-write
    localparam int TURN_CLK  = 2;

    function automatic int unsigned kind_index(col_cmd_e k);
        return (k == CMD_NOP) ? 0 : int'(k) - 1;
    endfunction

endpackage

// File: rtl/bc_gap_calc.sv
module bc_gap_calc
    import bc_spacing_pkg::*;
#(
    parameter int LAT_W = 5,
    localparam int GAP_W = LAT_W + 2
) (
    input  cmd_rec_t           last_i,
    input  logic [LAT_W-1:0]   cl_i,
    input  logic [LAT_W-1:0]   cwl_i,
    input  logic [LAT_W-1:0]   al_i,
    input  logic [LAT_W-1:0]   twtr_i,
    input  logic [LAT_W-1:0]   twr_i,
    output logic [GAP_W-1:0]   gap_o [NUM_KIND]
);

    localparam logic [GAP_W-1:0] ONE  = GAP_W'(1);
    localparam logic [GAP_W-1:0] SAME = GAP_W'(FULL_CLK);

    logic [GAP_W-1:0] cl_x, cwl_x, al_x, twtr_x, twr_x;
    logic [GAP_W-1:0] burst;
    logic [GAP_W-1:0] rw_sum;
    logic [GAP_W-1:0] rd_to_wr, wr_to_rd, wr_to_pre;

    assign cl_x   = GAP_W'(cl_i);
    assign cwl_x  = GAP_W'(cwl_i);
    assign al_x   = GAP_W'(al_i);
    assign twtr_x = GAP_W'(twtr_i);
    assign twr_x  = GAP_W'(twr_i);

    // Chop saving is taken from the earlier command's burst
    assign burst     = last_i.chop ? GAP_W'(CHOP_CLK) : GAP_W'(FULL_CLK);
    assign rw_sum    = cl_x + burst + GAP_W'(TURN_CLK);
    assign rd_to_wr  = (rw_sum > cwl_x) ? (rw_sum - cwl_x) : ONE;
    assign wr_to_rd  = cwl_x + burst + twtr_x;
    assign wr_to_pre = al_x + cwl_x + burst + twr_x;

    for (genvar n = 0; n < NUM_KIND; n++) begin : g_next
        localparam col_cmd_e NEXT = col_cmd_e'(2'(n + 1));
        logic [GAP_W-1:0] gap;

        always_comb begin
            gap = ONE;
            case (last_i.kind)
                CMD_RD: begin
                    if (NEXT == CMD_RD)      gap = SAME;
                    else if (NEXT == CMD_WR) gap = rd_to_wr;
                end
                CMD_WR: begin
                    if (NEXT == CMD_WR)      gap = SAME;
                    else if (NEXT == CMD_RD) gap = wr_to_rd;
                    else                     gap = wr_to_pre;
                end
                default: gap = ONE;
            endcase
        end

        assign gap_o[n] = gap;
    end

endmodule

// File: rtl/bc_cmd_tracker.sv
module bc_cmd_tracker
    import bc_spacing_pkg::*;
#(
    parameter int GAP_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept_i,
    input  cmd_rec_t         cmd_i,
    output cmd_rec_t         last_o,
    output logic             have_last_o,
    output logic [GAP_W-1:0] elapsed_o
);

    localparam logic [GAP_W-1:0] SAT = {GAP_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            last_o      <= '{kind: CMD_NOP, chop: 1'b0};
            have_last_o <= 1'b0;
            elapsed_o   <= '0;
        end else if (accept_i) begin
            last_o      <= cmd_i;
            have_last_o <= 1'b1;
            elapsed_o   <= GAP_W'(1);
        end else if (have_last_o && elapsed_o != SAT) begin
            elapsed_o   <= elapsed_o + GAP_W'(1);
        end
    end

    AST_RESTART_ON_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept_i |=> (elapsed_o == GAP_W'(1)) && have_last_o); // R7
    AST_IDLE_KEEPS_LAST: assert property (@(posedge clk) disable iff (rst)
        !accept_i |=> $stable(last_o)); // R8
    AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (elapsed_o == SAT && !accept_i) |=> elapsed_o == SAT); // R9

endmodule

// File: rtl/bc_ready_gate.sv
module bc_ready_gate
    import bc_spacing_pkg::*;
#(
    parameter int GAP_W = 7
) (
    input  col_cmd_e         kind_i,
    input  logic             have_last_i,
    input  logic [GAP_W-1:0] elapsed_i,
    input  logic [GAP_W-1:0] gap_i [NUM_KIND],
    output logic             rdy_o
);

    logic [GAP_W-1:0] need;

    always_comb begin
        need = GAP_W'(1);
        case (kind_i)
            CMD_RD:  need = gap_i[kind_index(CMD_RD)];
            CMD_WR:  need = gap_i[kind_index(CMD_WR)];
            CMD_PRE: need = gap_i[kind_index(CMD_PRE)];
            default: need = GAP_W'(1);
        endcase
    end

    assign rdy_o = !have_last_i || (kind_i == CMD_NOP) || (elapsed_i >= need);

endmodule

// File: rtl/bc_spacing_chk.sv
module bc_spacing_chk
    import bc_spacing_pkg::*;
#(
    parameter int LAT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_kind,
    input  logic             cmd_chop,
    input  logic [LAT_W-1:0] cfg_cl,
    input  logic [LAT_W-1:0] cfg_cwl,
    input  logic [LAT_W-1:0] cfg_al,
    input  logic [LAT_W-1:0] cfg_twtr,
    input  logic [LAT_W-1:0] cfg_twr,
    output logic             cmd_rdy,
    output logic             spacing_viol
);

    localparam int GAP_W = LAT_W + 2;

    col_cmd_e         kind;
    cmd_rec_t         cur_cmd;
    cmd_rec_t         last_cmd;
    logic             have_last;
    logic             accept;
    logic [GAP_W-1:0] elapsed;
    logic [GAP_W-1:0] gap [NUM_KIND];

    assign kind    = col_cmd_e'(cmd_kind);
    assign cur_cmd = '{kind: kind, chop: cmd_chop};
    assign accept  = cmd_valid && (kind != CMD_NOP);

    bc_gap_calc #(.LAT_W(LAT_W)) u_gap (
        .last_i (last_cmd),
        .cl_i   (cfg_cl),
        .cwl_i  (cfg_cwl),
        .al_i   (cfg_al),
        .twtr_i (cfg_twtr),
        .twr_i  (cfg_twr),
        .gap_o  (gap)
    );

    bc_cmd_tracker #(.GAP_W(GAP_W)) u_trk (
        .clk         (clk),
        .rst         (rst),
        .accept_i    (accept),
        .cmd_i       (cur_cmd),
        .last_o      (last_cmd),
        .have_last_o (have_last),
        .elapsed_o   (elapsed)
    );

    bc_ready_gate #(.GAP_W(GAP_W)) u_gate (
        .kind_i      (kind),
        .have_last_i (have_last),
        .elapsed_i   (elapsed),
        .gap_i       (gap),
        .rdy_o       (cmd_rdy)
    );

    always_ff @(posedge clk) begin
        if (rst) spacing_viol <= 1'b0;
        else     spacing_viol <= accept && !cmd_rdy;
    end

    AST_FIRST_FREE: assert property (@(posedge clk) disable iff (rst)
        !have_last |-> cmd_rdy); // R1
    AST_SAME_DIR_FULL: assert property (@(posedge clk) disable iff (rst)
        (have_last && last_cmd.kind == kind && (kind == CMD_RD || kind == CMD_WR)
         && elapsed < GAP_W'(FULL_CLK)) |-> !cmd_rdy); // R2
    AST_WR_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
        (have_last && last_cmd.kind == CMD_WR && kind == CMD_RD
         && elapsed < GAP_W'(cfg_cwl) + GAP_W'(CHOP_CLK) + GAP_W'(cfg_twtr)) |-> !cmd_rdy); // R4
    AST_WR_PRE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (have_last && last_cmd.kind == CMD_WR && kind == CMD_PRE
         && elapsed < GAP_W'(cfg_al) + GAP_W'(cfg_cwl) + GAP_W'(CHOP_CLK) + GAP_W'(cfg_twr))
        |-> !cmd_rdy); // R5
    AST_AFTER_PRE_FREE: assert property (@(posedge clk) disable iff (rst)
        (have_last && last_cmd.kind == CMD_PRE) |-> cmd_rdy); // R6
    AST_VIOL_FLAG: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && kind != CMD_NOP && !cmd_rdy) |=> spacing_viol); // R7
    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (rst)
        (kind == CMD_NOP) |=> !spacing_viol); // R8

endmodule

// File: tb/sim_bc_spacing_chk.sv
module sim_bc_spacing_chk;

    localparam int LAT_W = 4;
    localparam logic [1:0] NOP = 2'b00, RD = 2'b01, WR = 2'b10, PRE = 2'b11;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_valid = 1'b0;
    logic [1:0]       cmd_kind = NOP;
    logic             cmd_chop = 1'b0;
    logic [LAT_W-1:0] cfg_cl = 4'd6, cfg_cwl = 4'd5, cfg_al = 4'd1;
    logic [LAT_W-1:0] cfg_twtr = 4'd4, cfg_twr = 4'd6;
    logic             cmd_rdy, spacing_viol;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    bc_spacing_chk #(.LAT_W(LAT_W)) u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_kind(cmd_kind),
        .cmd_chop(cmd_chop), .cfg_cl(cfg_cl), .cfg_cwl(cfg_cwl), .cfg_al(cfg_al),
        .cfg_twtr(cfg_twtr), .cfg_twr(cfg_twr), .cmd_rdy(cmd_rdy),
        .spacing_viol(spacing_viol)
    );

    // {first kind, first chop, second kind, second chop, expected gap}
    localparam int NV = 13;
    localparam logic [11:0] VEC [NV] = '{
        {RD, 1'b0, RD,  1'b0, 6'd4},
        {RD, 1'b1, RD,  1'b1, 6'd4},
        {WR, 1'b1, WR,  1'b0, 6'd4},
        {WR, 1'b0, WR,  1'b1, 6'd4},
        {RD, 1'b0, WR,  1'b0, 6'd7},
        {RD, 1'b1, WR,  1'b1, 6'd5},
        {WR, 1'b0, RD,  1'b0, 6'd13},
        {WR, 1'b1, RD,  1'b1, 6'd11},
        {WR, 1'b0, PRE, 1'b0, 6'd16},
        {WR, 1'b1, PRE, 1'b0, 6'd14},
        {RD, 1'b1, PRE, 1'b0, 6'd1},
        {PRE,1'b0, RD,  1'b0, 6'd1},
        {PRE,1'b0, WR,  1'b1, 6'd1}
    };

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Called at a falling edge; returns at the next falling edge
    task automatic issue(input logic [1:0] k, input logic c);
        cmd_valid = 1'b1;
        cmd_kind  = k;
        cmd_chop  = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    function automatic string tag_of(input logic [1:0] a, input logic [1:0] b);
        if (a == b && a != PRE)  return "R2";
        if (a == RD && b == WR)  return "R3";
        if (a == WR && b == RD)  return "R4";
        if (a == WR && b == PRE) return "R5";
        return "R6";
    endfunction

    task automatic pair(input logic [1:0] k1, input logic c1, input logic [1:0] k2,
                        input logic c2, input int g, input string tag);
        issue(k1, c1);
        chk(spacing_viol == 1'b0, {tag, " first cmd no viol"}, int'(spacing_viol), 0);
        cmd_kind = k2;
        cmd_chop = c2;
        if (g > 1) begin
            repeat (g - 2) @(negedge clk);
            #1 chk(cmd_rdy == 1'b0, {tag, " held one clock early"}, int'(cmd_rdy), 0);
            @(negedge clk);
        end
        #1 chk(cmd_rdy == 1'b1, {tag, " ready at gap"}, int'(cmd_rdy), 1);
        issue(k2, c2);
        chk(spacing_viol == 1'b0, {tag, " on-time cmd no viol"}, int'(spacing_viol), 0);
        repeat (70) @(negedge clk);
    endtask

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        for (int k = 0; k < 4; k++) begin
            cmd_kind = 2'(k);
            #1 chk(cmd_rdy == 1'b1, "R1 ready in reset", int'(cmd_rdy), 1);
            chk(spacing_viol == 1'b0, "R1 viol in reset", int'(spacing_viol), 0);
        end
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Table walk: R2..R6, R10
        for (int i = 0; i < NV; i++) begin
            logic [1:0] k1, k2;
            k1 = VEC[i][11:10];
            k2 = VEC[i][8:7];
            pair(k1, VEC[i][9], k2, VEC[i][6], int'(VEC[i][5:0]), tag_of(k1, k2));
        end

        // R3 clamp: write latency above read latency plus burst
        cfg_cl = 4'd5; cfg_cwl = 4'd11;
        @(negedge clk);
        pair(RD, 1'b1, WR, 1'b0, 1, "R3 clamp chopped");
        pair(RD, 1'b0, WR, 1'b0, 1, "R3 clamp full");
        cfg_cl = 4'd6; cfg_cwl = 4'd5;
        @(negedge clk);

        // R7: early command flags a violation and becomes the reference
        issue(WR, 1'b0);
        repeat (2) @(negedge clk);
        cmd_kind = RD;
        #1 chk(cmd_rdy == 1'b0, "R10 read held after write", int'(cmd_rdy), 0);
        issue(RD, 1'b0);
        chk(spacing_viol == 1'b1, "R7 viol raised", int'(spacing_viol), 1);
        cmd_kind = WR;
        #1 chk(cmd_rdy == 1'b0, "R7 early read recorded", int'(cmd_rdy), 0);
        @(negedge clk);
        chk(spacing_viol == 1'b0, "R7 viol one clock", int'(spacing_viol), 0);
        repeat (70) @(negedge clk);

        // R8: no-op with valid is ignored
        issue(WR, 1'b0);
        repeat (3) @(negedge clk);
        issue(NOP, 1'b0);
        chk(spacing_viol == 1'b0, "R8 no-op no viol", int'(spacing_viol), 0);
        cmd_kind = RD;
        repeat (7) @(negedge clk);
        #1 chk(cmd_rdy == 1'b0, "R8 write timing kept", int'(cmd_rdy), 0);
        @(negedge clk);
        #1 chk(cmd_rdy == 1'b1, "R8 ready at write gap", int'(cmd_rdy), 1);
        repeat (70) @(negedge clk);

        // R9: saturation, not wrap
        issue(WR, 1'b0);
        repeat (68) @(negedge clk);
        cmd_kind = RD;
        #1 chk(cmd_rdy == 1'b1, "R9 saturated read", int'(cmd_rdy), 1);
        cmd_kind = PRE;
        #1 chk(cmd_rdy == 1'b1, "R9 saturated precharge", int'(cmd_rdy), 1);

        // R1: reset discards previous command
        @(negedge clk);
        issue(WR, 1'b0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        cmd_kind = RD;
        #1 chk(cmd_rdy == 1'b1, "R1 reset clears last", int'(cmd_rdy), 1);
        chk(spacing_viol == 1'b0, "R1 viol after reset", int'(spacing_viol), 0);

        summary();
    end

endmodule